// File: doc/BRIEF.md
# Serial Data-Flash Command Front End

This block is the slave side of a small serial data-flash model. A host selects it by pulling `csN` low, clocks in an opcode and three address bytes on `mosi`, and then writes or reads data. Behind the serial decoder are two independent SRAM page buffers and a small page-organised array. Commands copy a buffer into an array page, copy a page back into a buffer, or erase a page. Program and erase then run a self-timed busy period.

All serial pins are sampled into the system clock domain through two-stage synchronisers, so `sck` must run at least four times slower than `clk`. The serial output is a data bit plus an enable, which stands for a tri-stated pin. A hardware write-protect input silently drops program and erase commands but still accepts the two protection commands. `rstN` is both the system reset and the device reset pin.

Top module: `spi_flash_front`

## Requirements
- R1: A command starts only at a falling edge of `csN` and ends at the next rising edge. Bits clocked while `csN` stays low across a reset release, with no new falling edge, are not decoded.
- R2: Serial input is sampled on rising `sck` edges, MSB first. A command is an opcode byte followed by three address bytes. The low log2(PAGE_BYTES) address bits give the byte offset, and the next log2(NUM_PAGES) bits give the array page.
- R3: `misoOut` changes only after falling `sck` edges. The first read bit, which is bit 7, appears after the falling edge that follows the last opcode or address bit. `misoOe` is 0 whenever `csN` is high and 1 while it is low.
- R4: While `csN` is high, activity on `sck` and `mosi` changes no buffer, array or status state.
- R5: Opcodes 0x84 and 0x87 write buffer 1 and buffer 2. Opcodes 0xD4 and 0xD6 read them. Data follows the address directly. The two buffers are independent, and the offset wraps from PAGE_BYTES-1 to 0.
- R6: At the `csN` rise, 0x83 or 0x86 programs the addressed page from buffer 1 or buffer 2. 0x81 sets every byte of the page to 0xFF. 0x53 or 0x55 copies the page into buffer 1 or buffer 2 without a busy period.
- R7: Opcode 0xD7 returns a status byte, repeated and refreshed for every byte read. Bit 7 is 1 when ready, bit 1 is protection-enabled, bit 0 is lockdown, and all other bits are 0.
- R8: Program and erase hold bit 7 of the status byte at 0 for BUSY_CYCLES system clocks from the `csN` rise, whatever `csN` does meanwhile. Status can be read during this time.
- R9: While busy, every opcode other than 0xD7 is ignored.
- R10: If `wpN` is low when the opcode arrives, program and erase are discarded. No busy period starts and the array is unchanged.
- R11: Single-byte opcodes 0x3D (enable protection) and 0x77 (lockdown) set status bits 1 and 0 even when `wpN` is low.
- R12: A low `rstN` aborts a busy period and clears the protection bits. The block then reads status 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data into the block |
| wpN | input | 1 | Active-low hardware write protect |
| misoOut | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for the serial data pin (0 = high impedance) |

## Verification
The hardest state to reach is a command that arrives while the self-timed busy period is still running after `csN` has risen. The bench starts a program, reads status at once, and then sends a full buffer write. The busy length is set so that both transactions finish well inside it, and the bench later proves through a page transfer and read-back that the write was dropped. Aborting a busy period is reached in the same way, by pulsing `rstN` partway through. A reset released while `csN` stays low is reached by keeping the device selected across the pulse.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam logic [7:0] OP_BUF1_WR  = 8'h84;
  localparam logic [7:0] OP_BUF2_WR  = 8'h87;
  localparam logic [7:0] OP_BUF1_RD  = 8'hD4;
  localparam logic [7:0] OP_BUF2_RD  = 8'hD6;
  localparam logic [7:0] OP_PROG1    = 8'h83;
  localparam logic [7:0] OP_PROG2    = 8'h86;
  localparam logic [7:0] OP_ERASE    = 8'h81;
  localparam logic [7:0] OP_STATUS   = 8'hD7;
  localparam logic [7:0] OP_XFER1    = 8'h53;
  localparam logic [7:0] OP_XFER2    = 8'h55;
  localparam logic [7:0] OP_PROT_EN  = 8'h3D;
  localparam logic [7:0] OP_LOCKDOWN = 8'h77;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_DROP
  } cmdState_t;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_PROG, PEND_ERASE, PEND_XFER
  } pendOp_t;

  // control -> datapath: one-cycle strobes plus two level fields
  typedef struct packed {
    logic bufWr;      // write wrByte into buffer at offset
    logic outLoad;    // load output shifter
    logic outStatus;  // level: shifter source is status byte
    logic outShift;   // present next output bit
    logic progPage;   // copy buffer -> array page
    logic erasePage;  // fill array page with 0xFF
    logic xferPage;   // copy array page -> buffer
    logic bufSel;     // level: 0 = buffer 1, 1 = buffer 2
  } dpStrobe_t;

  function automatic logic isProgErase(input logic [7:0] op);
    return (op == OP_PROG1) || (op == OP_PROG2) || (op == OP_ERASE);
  endfunction

  function automatic logic isBufRead(input logic [7:0] op);
    return (op == OP_BUF1_RD) || (op == OP_BUF2_RD);
  endfunction

  function automatic logic isBufWrite(input logic [7:0] op);
    return (op == OP_BUF1_WR) || (op == OP_BUF2_WR);
  endfunction

  function automatic logic isXfer(input logic [7:0] op);
    return (op == OP_XFER1) || (op == OP_XFER2);
  endfunction

  function automatic logic selectsBuf2(input logic [7:0] op);
    return (op == OP_BUF2_WR) || (op == OP_BUF2_RD) ||
           (op == OP_PROG2) || (op == OP_XFER2);
  endfunction

endpackage

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_PAGES   = 4,
  parameter int BUSY_CYCLES = 5000,
  parameter int BYTE_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W      = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wpN,
  output dpStrobe_t         stb,
  output logic [BYTE_W-1:0] offset,
  output logic [PAGE_W-1:0] page,
  output logic [7:0]        wrByte,
  output logic [7:0]        statusByte
);

  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam int ADDR_W = BYTE_W + PAGE_W;
  localparam logic [BYTE_W-1:0] LAST_OFF = BYTE_W'(PAGE_BYTES - 1);

  // two-stage synchronisers for every serial pin
  logic [1:0] csQ, sckQ, mosiQ, wpQ;
  logic       csPrev, sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ     <= 2'b00;
      sckQ    <= 2'b00;
      mosiQ   <= 2'b00;
      wpQ     <= 2'b11;
      csPrev  <= 1'b0;
      sckPrev <= 1'b0;
    end else begin
      csQ     <= {csQ[0], csN};
      sckQ    <= {sckQ[0], sck};
      mosiQ   <= {mosiQ[0], mosi};
      wpQ     <= {wpQ[0], wpN};
      csPrev  <= csQ[1];
      sckPrev <= sckQ[1];
    end
  end

  logic csS, sckS, mosiS, wpS;
  logic csFall, csRise, sckRise, sckFall;
  assign csS     = csQ[1];
  assign sckS    = sckQ[1];
  assign mosiS   = mosiQ[1];
  assign wpS     = wpQ[1];
  assign csFall  = csPrev & ~csS;
  assign csRise  = ~csPrev & csS;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;

  cmdState_t         state;
  pendOp_t           pend;
  logic [2:0]        bitCnt;
  logic [1:0]        addrCnt;
  logic [6:0]        shiftIn;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  busyCnt;
  logic              protEn, lockDn, busy;
  logic [7:0]        inByte;
  logic [ADDR_W-1:0] fullAddr;

  assign inByte     = {shiftIn, mosiS};
  assign fullAddr   = ADDR_W'({addrReg, inByte});
  assign busy       = (busyCnt != '0);
  assign statusByte = {~busy, 5'b00000, protEn, lockDn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pend    <= PEND_NONE;
      bitCnt  <= '0;
      addrCnt <= '0;
      shiftIn <= '0;
      opcode  <= '0;
      addrReg <= '0;
      busyCnt <= '0;
      protEn  <= 1'b0;
      lockDn  <= 1'b0;
      offset  <= '0;
      page    <= '0;
      wrByte  <= '0;
      stb     <= '0;
    end else begin
      stb.bufWr     <= 1'b0;
      stb.outLoad   <= 1'b0;
      stb.outShift  <= 1'b0;
      stb.progPage  <= 1'b0;
      stb.erasePage <= 1'b0;
      stb.xferPage  <= 1'b0;

      if (busy) busyCnt <= busyCnt - 1'b1;

      // advance the byte offset once the datapath used it
      if (stb.bufWr || (stb.outLoad && !stb.outStatus))
        offset <= (offset == LAST_OFF) ? '0 : offset + 1'b1;

      if (sckFall && !csS) stb.outShift <= 1'b1;

      if (csFall) begin
        state   <= ST_CMD;
        bitCnt  <= '0;
        addrCnt <= '0;
        pend    <= PEND_NONE;
      end else if (csRise) begin
        state <= ST_IDLE;
        pend  <= PEND_NONE;
        unique case (pend)
          PEND_PROG: begin
            stb.progPage <= 1'b1;
            busyCnt      <= CNT_W'(BUSY_CYCLES);
          end
          PEND_ERASE: begin
            stb.erasePage <= 1'b1;
            busyCnt       <= CNT_W'(BUSY_CYCLES);
          end
          PEND_XFER: stb.xferPage <= 1'b1;
          default: ;
        endcase
      end else if (sckRise && !csS && state != ST_IDLE) begin
        shiftIn <= inByte[6:0];
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == 3'd7) begin
          unique case (state)
            ST_CMD: begin
              opcode <= inByte;
              if (inByte == OP_STATUS) begin
                state         <= ST_DATA;
                stb.outLoad   <= 1'b1;
                stb.outStatus <= 1'b1;
              end else begin
                stb.outStatus <= 1'b0;
                if (busy) begin
                  state <= ST_DROP;
                end else if (inByte == OP_PROT_EN) begin
                  protEn <= 1'b1;
                  state  <= ST_DROP;
                end else if (inByte == OP_LOCKDOWN) begin
                  lockDn <= 1'b1;
                  state  <= ST_DROP;
                end else if (isProgErase(inByte) && !wpS) begin
                  state <= ST_DROP;
                end else if (isProgErase(inByte) || isBufRead(inByte) ||
                             isBufWrite(inByte) || isXfer(inByte)) begin
                  state      <= ST_ADDR;
                  stb.bufSel <= selectsBuf2(inByte);
                end else begin
                  state <= ST_DROP;
                end
              end
            end
            ST_ADDR: begin
              addrReg <= fullAddr;
              addrCnt <= addrCnt + 1'b1;
              if (addrCnt == 2'd2) begin
                state  <= ST_DATA;
                offset <= fullAddr[BYTE_W-1:0];
                page   <= fullAddr[BYTE_W +: PAGE_W];
                if (isBufRead(opcode)) stb.outLoad <= 1'b1;
                if (opcode == OP_ERASE)      pend <= PEND_ERASE;
                else if (isProgErase(opcode)) pend <= PEND_PROG;
                else if (isXfer(opcode))      pend <= PEND_XFER;
              end
            end
            ST_DATA: begin
              if (isBufWrite(opcode)) begin
                wrByte    <= inByte;
                stb.bufWr <= 1'b1;
              end else if (isBufRead(opcode) || opcode == OP_STATUS) begin
                stb.outLoad <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_BUSY_FROM_CS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise)); // R8

  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && $past(state) == ST_CMD) |-> !$past(busy)); // R9

  AST_WP_GATES_PE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && $past(state) == ST_CMD && isProgErase(opcode))
      |-> $past(wpS)); // R10

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !stb.bufWr); // R4

endmodule

// File: rtl/spi_flash_dp.sv
module spi_flash_dp
  import spi_flash_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_PAGES  = 4,
  parameter int BYTE_W     = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] offset,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        wrByte,
  input  logic [7:0]        statusByte,
  output logic              misoBit
);

  logic [7:0] bufMem [2][PAGE_BYTES];
  logic [7:0] arrMem [NUM_PAGES][PAGE_BYTES];
  logic [7:0] outSh;

  // storage: no reset, contents survive rstN
  always_ff @(posedge clk) begin
    if (stb.bufWr) bufMem[stb.bufSel][offset] <= wrByte;
    if (stb.xferPage)
      for (int i = 0; i < PAGE_BYTES; i++) bufMem[stb.bufSel][i] <= arrMem[page][i];
    if (stb.progPage)
      for (int i = 0; i < PAGE_BYTES; i++) arrMem[page][i] <= bufMem[stb.bufSel][i];
    if (stb.erasePage)
      for (int i = 0; i < PAGE_BYTES; i++) arrMem[page][i] <= 8'hFF;
  end

  // output shifter: loaded after a rising sck, shifted after a falling one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSh   <= '0;
      misoBit <= 1'b0;
    end else if (stb.outLoad) begin
      outSh <= stb.outStatus ? statusByte : bufMem[stb.bufSel][offset];
    end else if (stb.outShift) begin
      misoBit <= outSh[7];
      outSh   <= {outSh[6:0], 1'b0};
    end
  end

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bufWr, stb.xferPage, stb.progPage, stb.erasePage})); // R6

  AST_LOAD_APART_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    stb.outLoad |-> !stb.outShift); // R3

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_flash_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_PAGES   = 4,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic wpN,
  output logic misoOut,
  output logic misoOe
);

  localparam int BYTE_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  dpStrobe_t         stb;
  logic [BYTE_W-1:0] offset;
  logic [PAGE_W-1:0] page;
  logic [7:0]        wrByte;
  logic [7:0]        statusByte;

  spi_flash_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES), .BUSY_CYCLES(BUSY_CYCLES),
    .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .wpN(wpN),
    .stb(stb), .offset(offset), .page(page), .wrByte(wrByte),
    .statusByte(statusByte)
  );

  spi_flash_dp #(
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .offset(offset), .page(page),
    .wrByte(wrByte), .statusByte(statusByte), .misoBit(misoOut)
  );

  assign misoOe = ~csN;

endmodule

// File: tb/spi_flash_front_tb.sv
`timescale 1ns/1ps
module spi_flash_front_tb;

  localparam int BUSY = 2000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, csN, sck, mosi, wpN;
  logic misoOut, misoOe;
  int nRun = 0, nFail = 0, cyc = 0, hiGlitch = 0;
  logic [7:0] junk;

  always @(posedge clk) cyc++;

  spi_flash_front #(.PAGE_BYTES(256), .NUM_PAGES(4), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .wpN(wpN),
    .misoOut(misoOut), .misoOe(misoOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed + 8'(k * 29);
  endfunction

  task automatic selectDev;
    csN = 1'b0;
    waitClk(6);
  endtask

  task automatic deselectDev;
    waitClk(6);
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitClk(6);
      rx[i] = misoOut;
      sck = 1'b1;
      waitClk(5);
      if (misoOut !== rx[i]) hiGlitch++;
      waitClk(1);
      sck = 1'b0;
    end
  endtask

  task automatic sendHdr(input logic [7:0] op, input int addr);
    xfer(op, junk);
    xfer(8'(addr >> 16), junk);
    xfer(8'(addr >> 8), junk);
    xfer(8'(addr), junk);
  endtask

  task automatic writeBuf(input bit sel, input int off, input int n, input logic [7:0] seed);
    selectDev();
    sendHdr(sel ? 8'h87 : 8'h84, off);
    for (int k = 0; k < n; k++) xfer(pat(seed, k), junk);
    deselectDev();
  endtask

  task automatic readCheck(input bit sel, input int off, input int n, input logic [7:0] seed,
                           input int k0, input bit erased, input string req);
    logic [7:0] rx;
    selectDev();
    sendHdr(sel ? 8'hD6 : 8'hD4, off);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx);
      chk(req, rx, erased ? 8'hFF : pat(seed, k0 + k));
    end
    deselectDev();
  endtask

  task automatic statusRead(output logic [7:0] st);
    selectDev();
    chk("R3 oe while selected", misoOe, 1'b1);
    xfer(8'hD7, junk);
    xfer(8'h00, st);
    deselectDev();
  endtask

  task automatic pageCmd(input logic [7:0] op, input int pg);
    selectDev();
    sendHdr(op, pg << 8);
    deselectDev();
  endtask

  task automatic singleCmd(input logic [7:0] op);
    selectDev();
    xfer(op, junk);
    deselectDev();
  endtask

  task automatic t_reset;
    logic [7:0] st;
    chk("R3 oe idle", misoOe, 1'b0);
    statusRead(st);
    chk("R7 status after reset", st, 8'h80);
  endtask

  task automatic t_buffers;
    writeBuf(0, 5, 3, 8'h11);
    writeBuf(1, 5, 3, 8'h22);
    readCheck(0, 5, 3, 8'h11, 0, 0, "R5 buffer1 read (R2 offset)");
    readCheck(1, 5, 3, 8'h22, 0, 0, "R5 buffer2 read");
    chk("R3 no glitch while sck high", hiGlitch, 0);
  endtask

  task automatic t_wrap;
    writeBuf(0, 254, 4, 8'h40);
    readCheck(0, 254, 4, 8'h40, 0, 0, "R5 wrap read");
    readCheck(0, 0, 2, 8'h40, 2, 0, "R5 wrapped bytes at offset 0");
  endtask

  task automatic t_deselect;
    csN = 1'b1;
    sendHdr(8'h84, 5);
    xfer(8'hEE, junk);
    readCheck(0, 5, 3, 8'h11, 0, 0, "R4 deselected bits ignored");
  endtask

  task automatic t_program_busy;
    logic [7:0] st;
    int t0;
    writeBuf(0, 0, 4, 8'h30);
    pageCmd(8'h83, 2);
    t0 = cyc;
    statusRead(st);
    chk("R8 busy after program", st, 8'h00);
    writeBuf(0, 0, 1, 8'hEE);
    statusRead(st);
    chk("R8 still busy after cs activity", st, 8'h00);
    while (cyc - t0 < BUSY + 100) waitClk(1);
    statusRead(st);
    chk("R8 ready after busy", st, 8'h80);
    pageCmd(8'h55, 2);
    readCheck(1, 0, 4, 8'h30, 0, 0, "R6 program then transfer");
    readCheck(0, 0, 4, 8'h30, 0, 0, "R9 write during busy ignored");
  endtask

  task automatic t_erase;
    pageCmd(8'h81, 2);
    waitClk(BUSY + 100);
    pageCmd(8'h53, 2);
    readCheck(0, 0, 4, 8'h00, 0, 1, "R6 erase gives FF");
  endtask

  task automatic t_write_protect;
    logic [7:0] st;
    writeBuf(0, 0, 4, 8'h50);
    pageCmd(8'h83, 1);
    waitClk(BUSY + 100);
    writeBuf(0, 0, 4, 8'h70);
    wpN = 1'b0;
    waitClk(4);
    pageCmd(8'h83, 1);
    statusRead(st);
    chk("R10 program dropped, no busy", st, 8'h80);
    pageCmd(8'h81, 1);
    statusRead(st);
    chk("R10 erase dropped, no busy", st, 8'h80);
    pageCmd(8'h55, 1);
    readCheck(1, 0, 4, 8'h50, 0, 0, "R10 array unchanged");
    singleCmd(8'h3D);
    statusRead(st);
    chk("R11 protect enable under wp", st, 8'h82);
    singleCmd(8'h77);
    statusRead(st);
    chk("R11 lockdown under wp", st, 8'h83);
    wpN = 1'b1;
    waitClk(4);
  endtask

  task automatic t_reset_abort;
    logic [7:0] st;
    pageCmd(8'h86, 3);
    waitClk(50);
    rstN = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    statusRead(st);
    chk("R12 reset aborts busy and clears protection", st, 8'h80);
    writeBuf(0, 9, 1, 8'hA0);
    csN = 1'b0;
    waitClk(6);
    rstN = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    sendHdr(8'h84, 9);
    xfer(8'h11, junk);
    deselectDev();
    readCheck(0, 9, 1, 8'hA0, 0, 0, "R1 no decode without cs fall");
  endtask

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    nFail++;
    $display("FAIL watchdog expired (all requirements)");
    finishRun();
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; mosi = 1'b0; wpN = 1'b1;
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);
    t_reset();
    t_buffers();
    t_wrap();
    t_deselect();
    t_program_busy();
    t_erase();
    t_write_protect();
    t_reset_abort();
    finishRun();
  end

endmodule